// File: doc/BRIEF.md
# Privilege Segment Address Decoder

This block takes a 32-bit virtual address, the current privilege level and an error-level status bit. It splits the address space into five fixed segments. Two segments are unmapped kernel windows. They produce a physical address through a fixed offset. Two segments are always translated and go out on a translation-lookaside port. The lowest half of the space is translated, except that with the error-level bit set it maps one-to-one. An access to a segment that the current privilege level may not use returns a bad-address result, and no lookup is made.

A request is accepted in any cycle in which `req_ready` is high. Requests that need no translation, and faulting requests, give a one-cycle response pulse on the clock edge after acceptance. Translated requests raise a lookup request that stays up until the lookup port answers. The answer is returned to the requester unchanged, one edge later. While a lookup is outstanding the decoder accepts no new request.

Top module: `seg_addr_decoder`

## Requirements
- R1: After reset, `rsp_valid` and `tlb_req_valid` are low and `req_ready` is high.
- R2: Addresses 0x00000000–0x7FFFFFFF with `err_level` set give, in any privilege level, a response one edge after acceptance. The response has `rsp_paddr` equal to the virtual address, both permission bits set and code 0 (match). No lookup is raised.
- R3: Addresses 0x00000000–0x7FFFFFFF with `err_level` clear raise `tlb_req_valid` one edge after acceptance, with `tlb_req_addr` and `tlb_req_write` equal to the request. One edge after `tlb_rsp_valid` is seen, the response carries the port's address, permission bits and code unchanged. This includes codes other than 0 and 1.
- R4: Addresses 0x80000000–0x9FFFFFFF in kernel level respond with `rsp_paddr` = address − 0x80000000, both permissions and code 0.
- R5: Addresses 0xA0000000–0xBFFFFFFF in kernel level respond with `rsp_paddr` = address − 0xA0000000, both permissions and code 0.
- R6: Addresses 0xC0000000–0xDFFFFFFF raise a lookup in supervisor or kernel level and fault in user level.
- R7: Addresses 0xE0000000–0xFFFFFFFF raise a lookup only in kernel level and fault in supervisor or user level.
- R8: A fault response has code 1 (bad address), both permission bits clear and `rsp_paddr` zero, arrives one edge after acceptance and raises no lookup. The windows of R4 and R5 fault in supervisor and user level.
- R9: `priv_mode` encodes kernel as 00, supervisor as 01 and user as 10. The value 11 behaves as user.
- R10: While a lookup is outstanding, `req_ready` is low and `tlb_req_valid`, `tlb_req_addr` and `tlb_req_write` hold their values until the edge at which `tlb_rsp_valid` is high. `tlb_req_valid` falls on that edge.
- R11: `err_level` has no effect on addresses at or above 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can accept a request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| priv_mode | input | 2 | Privilege level (00 kernel, 01 supervisor, 10/11 user) |
| err_level | input | 1 | Error-level status bit |
| tlb_req_valid | output | 1 | Lookup request, held until answered |
| tlb_req_addr | output | 32 | Address to translate |
| tlb_req_write | output | 1 | Lookup is for a write |
| tlb_rsp_valid | input | 1 | Lookup answer present |
| tlb_rsp_paddr | input | 32 | Translated address |
| tlb_rsp_rd | input | 1 | Read permitted by lookup |
| tlb_rsp_wr | input | 1 | Write permitted by lookup |
| tlb_rsp_code | input | 3 | Lookup result code |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_code | output | 3 | 0 match, 1 bad address, other values from the lookup port |

## Verification
The assertions check the lookup handshake on every cycle: the request is held stable, requests are refused while a lookup is outstanding, and the answer is forwarded one edge later. They also check that any fault response carries no permissions and a zero address, that both kernel windows apply their offsets, and that user level never reaches the upper half without a fault. The bench scenarios show the segment boundary addresses, the full privilege-by-segment matrix including the reserved mode value, and the error-level bit acting only on the lower half. They also show lookup latencies of zero and several cycles and pass-through of unusual lookup codes.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

   typedef enum logic [1:0] {
      PRIV_KERNEL = 2'b00,
      PRIV_SUPER  = 2'b01,
      PRIV_USER   = 2'b10,
      PRIV_RSVD   = 2'b11
   } priv_e;

   typedef enum logic [1:0] {
      ROUTE_DIRECT = 2'd0,
      ROUTE_TLB    = 2'd1,
      ROUTE_FAULT  = 2'd2
   } route_e;

   typedef struct packed {
      logic rd;
      logic wr;
   } perm_t;

endpackage

// File: rtl/seg_priv_decode.sv
module seg_priv_decode #(
   parameter bit RSVD_AS_USER = 1'b1
) (
   input  logic [1:0] priv_mode,
   output logic       is_kernel,
   output logic       is_super,
   output logic       is_user
);
   import seg_dec_pkg::*;

   assign is_super = (priv_mode == PRIV_SUPER);

   generate
      if (RSVD_AS_USER) begin : g_rsvd_user
         assign is_user = priv_mode[1];
      end else begin : g_rsvd_kernel
         assign is_user = (priv_mode == PRIV_USER);
      end
   endgenerate

   assign is_kernel = !is_user && !is_super;

endmodule

// File: rtl/seg_classify.sv
module seg_classify #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              err_level,
   input  logic              is_kernel,
   input  logic              is_super,
   output seg_dec_pkg::route_e route,
   output logic [ADDR_W-1:0] direct_paddr
);
   import seg_dec_pkg::*;

   localparam logic [ADDR_W-1:0] WIN_CACHED_BASE   = ADDR_W'(32'h8000_0000);
   localparam logic [ADDR_W-1:0] WIN_UNCACHED_BASE = ADDR_W'(32'hA000_0000);
   localparam int                TOP_BIT           = ADDR_W - 1;

   logic [2:0] region;
   assign region = vaddr[TOP_BIT -: 3];

   always_comb begin
      route        = ROUTE_FAULT;
      direct_paddr = '0;
      casez (region)
         3'b0?? : begin
            if (err_level) begin
               route        = ROUTE_DIRECT;
               direct_paddr = vaddr;
            end else begin
               route = ROUTE_TLB;
            end
         end
         3'b100 : begin
            if (is_kernel) begin
               route        = ROUTE_DIRECT;
               direct_paddr = vaddr - WIN_CACHED_BASE;
            end
         end
         3'b101 : begin
            if (is_kernel) begin
               route        = ROUTE_DIRECT;
               direct_paddr = vaddr - WIN_UNCACHED_BASE;
            end
         end
         3'b110 : begin
            if (is_kernel || is_super) route = ROUTE_TLB;
         end
         default : begin
            if (is_kernel) route = ROUTE_TLB;
         end
      endcase
   end

endmodule

// File: rtl/seg_xact_ctrl.sv
module seg_xact_ctrl #(
   parameter int                ADDR_W     = 32,
   parameter int                CODE_W     = 3,
   parameter logic [CODE_W-1:0] CODE_MATCH = '0,
   parameter logic [CODE_W-1:0] CODE_BAD   = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_write,
   input  seg_dec_pkg::route_e route,
   input  logic [ADDR_W-1:0]   direct_paddr,
   output logic                tlb_req_valid,
   output logic [ADDR_W-1:0]   tlb_req_addr,
   output logic                tlb_req_write,
   input  logic                tlb_rsp_valid,
   input  logic [ADDR_W-1:0]   tlb_rsp_paddr,
   input  seg_dec_pkg::perm_t  tlb_rsp_perm,
   input  logic [CODE_W-1:0]   tlb_rsp_code,
   output logic                rsp_valid,
   output logic [ADDR_W-1:0]   rsp_paddr,
   output seg_dec_pkg::perm_t  rsp_perm,
   output logic [CODE_W-1:0]   rsp_code
);
   import seg_dec_pkg::*;

   localparam perm_t PERM_ALL  = '{rd: 1'b1, wr: 1'b1};
   localparam perm_t PERM_NONE = '{rd: 1'b0, wr: 1'b0};

   logic waiting;
   logic accept;

   assign req_ready     = !waiting;
   assign accept        = req_valid && !waiting;
   assign tlb_req_valid = waiting;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waiting       <= 1'b0;
         tlb_req_addr  <= '0;
         tlb_req_write <= 1'b0;
         rsp_valid     <= 1'b0;
         rsp_paddr     <= '0;
         rsp_perm      <= PERM_NONE;
         rsp_code      <= CODE_MATCH;
      end else begin
         rsp_valid <= 1'b0;
         if (accept) begin
            unique case (route)
               ROUTE_DIRECT : begin
                  rsp_valid <= 1'b1;
                  rsp_paddr <= direct_paddr;
                  rsp_perm  <= PERM_ALL;
                  rsp_code  <= CODE_MATCH;
               end
               ROUTE_TLB : begin
                  waiting       <= 1'b1;
                  tlb_req_addr  <= req_addr;
                  tlb_req_write <= req_write;
               end
               default : begin
                  rsp_valid <= 1'b1;
                  rsp_paddr <= '0;
                  rsp_perm  <= PERM_NONE;
                  rsp_code  <= CODE_BAD;
               end
            endcase
         end else if (waiting && tlb_rsp_valid) begin
            waiting   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_paddr <= tlb_rsp_paddr;
            rsp_perm  <= tlb_rsp_perm;
            rsp_code  <= tlb_rsp_code;
         end
      end
   end

endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder #(
   parameter int                ADDR_W       = 32,
   parameter int                CODE_W       = 3,
   parameter logic [CODE_W-1:0] CODE_MATCH   = '0,
   parameter logic [CODE_W-1:0] CODE_BAD     = 1,
   parameter bit                RSVD_AS_USER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [1:0]        priv_mode,
   input  logic              err_level,
   output logic              tlb_req_valid,
   output logic [ADDR_W-1:0] tlb_req_addr,
   output logic              tlb_req_write,
   input  logic              tlb_rsp_valid,
   input  logic [ADDR_W-1:0] tlb_rsp_paddr,
   input  logic              tlb_rsp_rd,
   input  logic              tlb_rsp_wr,
   input  logic [CODE_W-1:0] tlb_rsp_code,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_paddr,
   output logic              rsp_rd,
   output logic              rsp_wr,
   output logic [CODE_W-1:0] rsp_code
);
   import seg_dec_pkg::*;

   generate
      if (ADDR_W != 32) begin : g_bad_addr_w
         $error("seg_addr_decoder: segment map is defined for 32-bit addresses only");
      end
      if (CODE_W < 2) begin : g_bad_code_w
         $error("seg_addr_decoder: CODE_W must hold at least two distinct codes");
      end
      if (CODE_MATCH == CODE_BAD) begin : g_bad_codes
         $error("seg_addr_decoder: match and bad-address codes must differ");
      end
   endgenerate

   logic                is_kernel;
   logic                is_super;
   logic                is_user;
   route_e              route;
   logic [ADDR_W-1:0]   direct_paddr;
   perm_t               tlb_perm;
   perm_t               out_perm;

   assign tlb_perm = '{rd: tlb_rsp_rd, wr: tlb_rsp_wr};
   assign rsp_rd   = out_perm.rd;
   assign rsp_wr   = out_perm.wr;

   seg_priv_decode #(
      .RSVD_AS_USER (RSVD_AS_USER)
   ) u_priv (
      .priv_mode (priv_mode),
      .is_kernel (is_kernel),
      .is_super  (is_super),
      .is_user   (is_user)
   );

   seg_classify #(
      .ADDR_W (ADDR_W)
   ) u_classify (
      .vaddr        (req_addr),
      .err_level    (err_level),
      .is_kernel    (is_kernel),
      .is_super     (is_super),
      .route        (route),
      .direct_paddr (direct_paddr)
   );

   seg_xact_ctrl #(
      .ADDR_W     (ADDR_W),
      .CODE_W     (CODE_W),
      .CODE_MATCH (CODE_MATCH),
      .CODE_BAD   (CODE_BAD)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .req_write     (req_write),
      .route         (route),
      .direct_paddr  (direct_paddr),
      .tlb_req_valid (tlb_req_valid),
      .tlb_req_addr  (tlb_req_addr),
      .tlb_req_write (tlb_req_write),
      .tlb_rsp_valid (tlb_rsp_valid),
      .tlb_rsp_paddr (tlb_rsp_paddr),
      .tlb_rsp_perm  (tlb_perm),
      .tlb_rsp_code  (tlb_rsp_code),
      .rsp_valid     (rsp_valid),
      .rsp_paddr     (rsp_paddr),
      .rsp_perm      (out_perm),
      .rsp_code      (rsp_code)
   );

   logic unused_user;
   assign unused_user = is_user;

endmodule

// File: rtl/seg_addr_decoder_chk.sv
module seg_addr_decoder_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                CODE_W     = 3,
   parameter logic [CODE_W-1:0] CODE_MATCH = '0,
   parameter logic [CODE_W-1:0] CODE_BAD   = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        priv_mode,
   input logic              tlb_req_valid,
   input logic [ADDR_W-1:0] tlb_req_addr,
   input logic              tlb_req_write,
   input logic              tlb_rsp_valid,
   input logic [ADDR_W-1:0] tlb_rsp_paddr,
   input logic [CODE_W-1:0] tlb_rsp_code,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_paddr,
   input logic              rsp_rd,
   input logic              rsp_wr,
   input logic [CODE_W-1:0] rsp_code
);

   // R10: lookup request held until answered
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid && !tlb_rsp_valid |=>
         tlb_req_valid && $stable(tlb_req_addr) && $stable(tlb_req_write));

   // R10: no acceptance while a lookup is outstanding
   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid |-> !req_ready);

   // R3: lookup answer forwarded one edge later
   p_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_req_valid && tlb_rsp_valid |=>
         rsp_valid && !tlb_req_valid && rsp_paddr == $past(tlb_rsp_paddr)
         && rsp_code == $past(tlb_rsp_code));

   // R8: fault responses grant nothing
   p_fault_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_code == CODE_BAD && !$past(tlb_req_valid) |->
         !rsp_rd && !rsp_wr && rsp_paddr == '0);

   // R4 / R5: kernel windows strip the top three address bits
   p_kwin_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_addr[ADDR_W-1 -: 2] == 2'b10 && priv_mode == 2'b00 |=>
         rsp_valid && rsp_code == CODE_MATCH && rsp_rd && rsp_wr
         && rsp_paddr == {3'b000, $past(req_addr[ADDR_W-4:0])});

   // R6 / R7 / R9: user level faults on the whole upper half
   p_user_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_addr[ADDR_W-1] && priv_mode[1] |=>
         rsp_valid && rsp_code == CODE_BAD && !tlb_req_valid);

endmodule

bind seg_addr_decoder seg_addr_decoder_chk #(
   .ADDR_W     (ADDR_W),
   .CODE_W     (CODE_W),
   .CODE_MATCH (CODE_MATCH),
   .CODE_BAD   (CODE_BAD)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .priv_mode     (priv_mode),
   .tlb_req_valid (tlb_req_valid),
   .tlb_req_addr  (tlb_req_addr),
   .tlb_req_write (tlb_req_write),
   .tlb_rsp_valid (tlb_rsp_valid),
   .tlb_rsp_paddr (tlb_rsp_paddr),
   .tlb_rsp_code  (tlb_rsp_code),
   .rsp_valid     (rsp_valid),
   .rsp_paddr     (rsp_paddr),
   .rsp_rd        (rsp_rd),
   .rsp_wr        (rsp_wr),
   .rsp_code      (rsp_code)
);

// File: tb/tb_seg_addr_decoder.sv
`timescale 1ns/1ps
module tb_seg_addr_decoder;

   localparam logic [1:0] M_K = 2'b00;
   localparam logic [1:0] M_S = 2'b01;
   localparam logic [1:0] M_U = 2'b10;
   localparam logic [1:0] M_R = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [1:0]  priv_mode = 2'b00;
   logic        err_level = 1'b0;
   logic        tlb_req_valid;
   logic [31:0] tlb_req_addr;
   logic        tlb_req_write;
   logic        tlb_rsp_valid = 1'b0;
   logic [31:0] tlb_rsp_paddr = '0;
   logic        tlb_rsp_rd = 1'b0;
   logic        tlb_rsp_wr = 1'b0;
   logic [2:0]  tlb_rsp_code = '0;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_rd;
   logic        rsp_wr;
   logic [2:0]  rsp_code;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   seg_addr_decoder dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_addr      (req_addr),
      .req_write     (req_write),
      .priv_mode     (priv_mode),
      .err_level     (err_level),
      .tlb_req_valid (tlb_req_valid),
      .tlb_req_addr  (tlb_req_addr),
      .tlb_req_write (tlb_req_write),
      .tlb_rsp_valid (tlb_rsp_valid),
      .tlb_rsp_paddr (tlb_rsp_paddr),
      .tlb_rsp_rd    (tlb_rsp_rd),
      .tlb_rsp_wr    (tlb_rsp_wr),
      .tlb_rsp_code  (tlb_rsp_code),
      .rsp_valid     (rsp_valid),
      .rsp_paddr     (rsp_paddr),
      .rsp_rd        (rsp_rd),
      .rsp_wr        (rsp_wr),
      .rsp_code      (rsp_code)
   );

   task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
      end
   endtask

   // drive a request, leave at the negedge after the accepting edge
   task automatic send(input logic [31:0] a, input logic w, input logic [1:0] m, input logic e);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w; priv_mode = m; err_level = e;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_direct(input string rq, input logic [31:0] pa);
      check({rq, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      check({rq, " paddr"}, 64'(rsp_paddr), 64'(pa));
      check({rq, " perm"}, 64'({rsp_rd, rsp_wr}), 64'd3);
      check({rq, " code"}, 64'(rsp_code), 64'd0);
      check({rq, " no lookup"}, 64'(tlb_req_valid), 64'd0);
   endtask

   task automatic expect_fault(input string rq);
      check({rq, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      check({rq, " code"}, 64'(rsp_code), 64'd1);
      check({rq, " perm"}, 64'({rsp_rd, rsp_wr}), 64'd0);
      check({rq, " paddr"}, 64'(rsp_paddr), 64'd0);
      check({rq, " no lookup"}, 64'(tlb_req_valid), 64'd0);
   endtask

   // lookup issued: check it, wait d cycles, answer, check forwarded result
   task automatic tlb_round(input string rq, input logic [31:0] a, input logic w, input int d,
                            input logic [31:0] pa, input logic rd, input logic wr, input logic [2:0] c);
      check({rq, " lookup raised"}, 64'(tlb_req_valid), 64'd1);
      check({rq, " lookup addr"}, 64'(tlb_req_addr), 64'(a));
      check({rq, " lookup write"}, 64'(tlb_req_write), 64'(w));
      check({rq, " no early rsp"}, 64'(rsp_valid), 64'd0);
      for (int i = 0; i < d; i++) begin
         check({rq, " R10 busy"}, 64'(req_ready), 64'd0);
         @(negedge clk);
         check({rq, " R10 held"}, 64'({tlb_req_valid, tlb_req_write, tlb_req_addr}), 64'({1'b1, w, a}));
      end
      tlb_rsp_valid = 1'b1; tlb_rsp_paddr = pa; tlb_rsp_rd = rd; tlb_rsp_wr = wr; tlb_rsp_code = c;
      @(posedge clk);
      @(negedge clk);
      tlb_rsp_valid = 1'b0;
      check({rq, " R3 rsp_valid"}, 64'(rsp_valid), 64'd1);
      check({rq, " R3 paddr"}, 64'(rsp_paddr), 64'(pa));
      check({rq, " R3 perm"}, 64'({rsp_rd, rsp_wr}), 64'({rd, wr}));
      check({rq, " R3 code"}, 64'(rsp_code), 64'(c));
      check({rq, " R10 released"}, 64'({tlb_req_valid, req_ready}), 64'b01);
   endtask

   task automatic t_reset;
      check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
      check("R1 tlb_req_valid", 64'(tlb_req_valid), 64'd0);
      check("R1 req_ready", 64'(req_ready), 64'd1);
   endtask

   task automatic t_user_erl;
      send(32'h0000_0000, 1'b0, M_U, 1'b1); expect_direct("R2 low edge", 32'h0000_0000);
      send(32'h7FFF_FFFF, 1'b1, M_S, 1'b1); expect_direct("R2 high edge", 32'h7FFF_FFFF);
      send(32'h1234_5678, 1'b1, M_K, 1'b1); expect_direct("R2 kernel", 32'h1234_5678);
   endtask

   task automatic t_user_tlb;
      send(32'h0040_1000, 1'b0, M_U, 1'b0);
      tlb_round("R3 d0", 32'h0040_1000, 1'b0, 0, 32'h0ABC_D000, 1'b1, 1'b0, 3'd0);
      send(32'h7FFF_FFFC, 1'b1, M_U, 1'b0);
      tlb_round("R3 d4 nomatch", 32'h7FFF_FFFC, 1'b1, 4, 32'h0000_0000, 1'b0, 1'b0, 3'd2);
      send(32'h0000_2000, 1'b1, M_K, 1'b0);
      tlb_round("R3 d2 dirty", 32'h0000_2000, 1'b1, 2, 32'h1111_2000, 1'b1, 1'b0, 3'd4);
   endtask

   task automatic t_kwin;
      send(32'h8000_0000, 1'b0, M_K, 1'b0); expect_direct("R4 low", 32'h0000_0000);
      send(32'h9FFF_FFFF, 1'b1, M_K, 1'b0); expect_direct("R4 high", 32'h1FFF_FFFF);
      send(32'hA000_0000, 1'b0, M_K, 1'b0); expect_direct("R5 low", 32'h0000_0000);
      send(32'hBFFF_F004, 1'b1, M_K, 1'b0); expect_direct("R5 high", 32'h1FFF_F004);
      send(32'h9000_0000, 1'b0, M_S, 1'b0); expect_fault("R8 super win");
      send(32'hA800_0000, 1'b0, M_U, 1'b0); expect_fault("R8 user win");
   endtask

   task automatic t_sup_seg;
      send(32'hC000_0000, 1'b0, M_S, 1'b0);
      tlb_round("R6 super", 32'hC000_0000, 1'b0, 1, 32'h2000_0000, 1'b1, 1'b1, 3'd0);
      send(32'hDFFF_FFF0, 1'b1, M_K, 1'b0);
      tlb_round("R6 kernel", 32'hDFFF_FFF0, 1'b1, 0, 32'h2FFF_FFF0, 1'b1, 1'b1, 3'd3);
      send(32'hC800_0000, 1'b0, M_U, 1'b0); expect_fault("R6 user");
   endtask

   task automatic t_kern_seg;
      send(32'hE000_0000, 1'b0, M_K, 1'b0);
      tlb_round("R7 kernel", 32'hE000_0000, 1'b0, 3, 32'h3000_0000, 1'b1, 1'b0, 3'd7);
      send(32'hFFFF_FFFF, 1'b0, M_S, 1'b0); expect_fault("R7 super");
      send(32'hE000_0000, 1'b1, M_U, 1'b0); expect_fault("R7 user");
   endtask

   task automatic t_mode_rsvd;
      send(32'h8000_1000, 1'b0, M_R, 1'b0); expect_fault("R9 mode11 win");
      send(32'hC000_1000, 1'b0, M_R, 1'b0); expect_fault("R9 mode11 sseg");
      send(32'h0000_1000, 1'b0, M_R, 1'b1); expect_direct("R9 mode11 low", 32'h0000_1000);
   endtask

   task automatic t_erl_upper;
      send(32'h8765_4320, 1'b0, M_K, 1'b1); expect_direct("R11 win", 32'h0765_4320);
      send(32'h8765_4320, 1'b0, M_U, 1'b1); expect_fault("R11 user");
      send(32'hE000_4000, 1'b0, M_K, 1'b1);
      tlb_round("R11 kseg", 32'hE000_4000, 1'b0, 0, 32'h0000_4000, 1'b1, 1'b1, 3'd0);
   endtask

   task automatic t_busy_ignore;
      // R10: a request presented while waiting is not taken
      send(32'h0000_8000, 1'b0, M_U, 1'b0);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h8000_0000; priv_mode = M_K;
      @(negedge clk);
      check("R10 not accepted", 64'(rsp_valid), 64'd0);
      req_valid = 1'b0;
      tlb_round("R10 wait", 32'h0000_8000, 1'b0, 1, 32'h0000_9000, 1'b1, 1'b1, 3'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_user_erl();
      t_user_tlb();
      t_kwin();
      t_sup_seg();
      t_kern_seg();
      t_mode_rsvd();
      t_erl_upper();
      t_busy_ignore();
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule